// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

A 32-bit countdown timer that belongs to a single processor core and is reached through a small word-addressed register port. Software sets a reload value, a prescale factor and a mode. The counter then steps down once every P+1 clock cycles. When it runs out, it raises a level interrupt. In periodic mode the counter refills from the stored reload value and keeps going. In one-shot mode it parks at zero until software intervenes.

Software may replace the live count at any time. It can do this directly, or by writing a new reload value, which also refills the counter. Either write restarts the prescale phase. The interrupt flag is cleared by writing a one to it. Turning the timer on in periodic mode while the count is zero first fills the counter from the reload value, so that no extra write is needed.

Top module: `prescaled_down_timer`

## Requirements
- R1: A synchronous reset clears the reload value, the counter, the control word and the interrupt flag to zero. After reset the irq output is low.
- R2: Byte offset 0x0 selects the reload value, 0x4 the counter, 0x8 the control word and 0xC the flag. Any other offset, including an unaligned one, reads as zero and ignores writes. In the control word, bit 0 enables counting, bit 1 selects periodic mode and bits 15:8 hold the prescale factor P. All other control bits read back as zero.
- R3: While enabled with a nonzero count, the counter drops by one every P+1 clock cycles. The first drop comes P+1 cycles after the write that started or restarted the countdown.
- R4: A write to offset 0x0 stores the value as the reload value and also copies it into the counter, restarting the prescale phase.
- R5: A write to offset 0x4 replaces the counter with the written value and restarts the prescale phase.
- R6: When a drop takes the counter from 1 to 0, the flag (bit 0 at 0xC) is set. In one-shot mode (control bit 1 clear) the counter then stays at zero.
- R7: In periodic mode, the drop that ends a period loads the counter with the reload value instead of zero, and counting continues.
- R8: A control write that changes bit 0 from 0 to 1 while the counter is zero and bit 1 is set in the written word first loads the counter from the reload value.
- R9: A read of offset 0x4 returns zero while the timer is disabled or the count is zero. While disabled the count does not change except by register writes.
- R10: Writing offset 0xC clears the flag when bit 0 of the written data is 1 and leaves it alone when it is 0. The irq output always equals the flag.
- R11: An enabled timer whose count is zero does not count and raises no new interrupt.
- R12: In the same cycle, an expiry wins over a flag-clear write, so the flag stays set. A register write to the counter or reload value wins over a decrement, so the written value is read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, equal to the flag |

## Verification
Two events can land on the same clock edge: the expiry that sets the flag, and a software write that clears it. The bench starts a one-shot countdown of nine with P = 0 and times the clear write to hit the expiry edge. The flag must still read 1. A clear one edge later must bring it to 0. In the same way, a counter write is placed on an edge where a decrement is due with P = 0, and the exact written value must read back rather than one less.

// File: rtl/ptim_pkg.sv
package ptim_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned PSC_W   = 8;
  localparam int unsigned PSC_LSB = 8;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_FLAG  = 2'd3
  } sel_e;

  typedef struct packed {
    logic [PSC_W-1:0] scale;
    logic             reload;
    logic             enable;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [BUS_W-1:0] w);
    ctrl_t c;
    c.enable = w[0];
    c.reload = w[1];
    c.scale  = w[PSC_LSB +: PSC_W];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[0] = c.enable;
    w[1] = c.reload;
    w[PSC_LSB +: PSC_W] = c.scale;
    return w;
  endfunction
endpackage

// File: rtl/ptim_prescaler.sv
module ptim_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] period,
  output logic         tick
);
  logic [W-1:0] psc_q;

  function automatic logic [W-1:0] psc_next(input logic [W-1:0] cur, input logic [W-1:0] per);
    return (cur == '0) ? per : cur - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          psc_q <= '0;
    else if (restart) psc_q <= period;
    else if (run)     psc_q <= psc_next(psc_q, period);
  end

  assign tick = run && !restart && (psc_q == '0);

  assert_psc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && psc_q != '0) |=> (psc_q == $past(psc_q) - 1'b1));
  assert_psc_restart_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (psc_q == $past(period)));
endmodule

// File: rtl/ptim_counter.sv
module ptim_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_load,
  input  logic         wr_count,
  input  logic [W-1:0] wdata,
  input  logic         preload,
  input  logic         periodic,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic [W-1:0] load,
  output logic         expire
);
  logic [W-1:0] cnt_q, load_q;

  function automatic logic [W-1:0] after_tick(input logic [W-1:0] c, input logic [W-1:0] ld,
                                              input logic per);
    if (c == W'(1)) return per ? ld : '0;
    return c - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else if (wr_load) begin
      load_q <= wdata;
      cnt_q  <= wdata;
    end else if (wr_count) begin
      cnt_q <= wdata;
    end else if (preload && cnt_q == '0) begin
      cnt_q <= load_q;
    end else if (tick) begin
      cnt_q <= after_tick(cnt_q, load_q, periodic);
    end
  end

  assign expire = tick && (cnt_q == W'(1));
  assign cnt    = cnt_q;
  assign load   = load_q;

  assert_oneshot_park_R6: assert property (@(posedge clk) disable iff (rst)
    (expire && !periodic && !wr_load && !wr_count) |=> (cnt_q == '0));
  assert_periodic_refill_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && periodic && !wr_load && !wr_count) |=> (cnt_q == $past(load_q)));
  assert_count_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_count && !wr_load) |=> (cnt_q == $past(wdata)));
  assert_load_copies_R4: assert property (@(posedge clk) disable iff (rst)
    wr_load |=> (cnt_q == load_q));
endmodule

// File: rtl/ptim_flag.sv
module ptim_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  assert_clear_works_R10: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag_q);
  assert_set_beats_clear_R12: assert property (@(posedge clk) disable iff (rst)
    set |=> flag_q);
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer
  import ptim_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned MAP_W   = SEL_LSB + 2;

  logic              hit, wr_load, wr_count, wr_ctrl, wr_flag;
  logic              en_rise, preload, run, restart, tick, expire, flag;
  logic [PSC_W-1:0]  psc_period;
  logic [BUS_W-1:0]  cnt_val, load_val;
  sel_e              sel;
  ctrl_t             ctrl_q, ctrl_new;

  function automatic logic [BUS_W-1:0] visible_count(input logic en, input logic [BUS_W-1:0] c);
    return en ? c : '0;
  endfunction

  assign hit      = (addr[SEL_LSB-1:0] == '0) && ((addr >> MAP_W) == '0);
  assign sel      = sel_e'(addr[SEL_LSB +: 2]);
  assign wr_load  = wr_en && hit && (sel == SEL_LOAD);
  assign wr_count = wr_en && hit && (sel == SEL_COUNT);
  assign wr_ctrl  = wr_en && hit && (sel == SEL_CTRL);
  assign wr_flag  = wr_en && hit && (sel == SEL_FLAG);

  assign ctrl_new = ctrl_from_word(wdata);
  assign en_rise  = wr_ctrl && !ctrl_q.enable && ctrl_new.enable;
  assign preload  = en_rise && ctrl_new.reload;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_new;
  end

  assign run        = ctrl_q.enable && (cnt_val != '0);
  assign restart    = wr_load || wr_count || en_rise;
  assign psc_period = wr_ctrl ? ctrl_new.scale : ctrl_q.scale;

  ptim_prescaler #(.W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(run), .restart(restart),
    .period(psc_period), .tick(tick)
  );

  ptim_counter #(.W(BUS_W)) u_cnt (
    .clk(clk), .rst(rst), .wr_load(wr_load), .wr_count(wr_count),
    .wdata(wdata), .preload(preload), .periodic(ctrl_q.reload),
    .tick(tick), .cnt(cnt_val), .load(load_val), .expire(expire)
  );

  ptim_flag u_flag (
    .clk(clk), .rst(rst), .set(expire), .clr(wr_flag && wdata[0]), .flag(flag)
  );

  assign irq = flag;

  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (sel)
        SEL_LOAD:  rdata = load_val;
        SEL_COUNT: rdata = visible_count(ctrl_q.enable, cnt_val);
        SEL_CTRL:  rdata = ctrl_to_word(ctrl_q);
        SEL_FLAG:  rdata = {{(BUS_W-1){1'b0}}, flag};
        default:   rdata = '0;
      endcase
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt_val == '0 && load_val == '0 && ctrl_q == '0 && !irq));
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(expire));
  assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.enable && !wr_load && !wr_count && !preload) |=> $stable(cnt_val));
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.enable && cnt_val == '0 && !wr_load && !wr_count) |=> (cnt_val == '0 && !$rose(irq)));
endmodule

// File: tb/prescaled_down_timer_tb_top.sv
module prescaled_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  prescaled_down_timer #(.ADDR_W(4)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  p;
    logic        ar;
    logic [15:0] v;
    logic [15:0] w;
    logic [31:0] ecnt;
    logic        ests;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   1'b0, 16'd5,  16'd3,   32'd2,  1'b0},
    '{8'd0,   1'b0, 16'd5,  16'd5,   32'd0,  1'b1},
    '{8'd0,   1'b0, 16'd5,  16'd9,   32'd0,  1'b1},
    '{8'd3,   1'b0, 16'd4,  16'd7,   32'd3,  1'b0},
    '{8'd3,   1'b0, 16'd4,  16'd16,  32'd0,  1'b1},
    '{8'd1,   1'b1, 16'd3,  16'd6,   32'd3,  1'b1},
    '{8'd1,   1'b1, 16'd3,  16'd8,   32'd2,  1'b1},
    '{8'd0,   1'b1, 16'd1,  16'd4,   32'd1,  1'b1},
    '{8'd255, 1'b0, 16'd2,  16'd300, 32'd1,  1'b0},
    '{8'd7,   1'b1, 16'd10, 16'd100, 32'd8,  1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    wr_en = 1'b0; addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R3 act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst = 1'b0;

    // R1: reset state
    rd(4'h0, d); check("R1 load", d, 32'h0);
    rd(4'h4, d); check("R1 count", d, 32'h0);
    rd(4'h8, d); check("R1 ctrl", d, 32'h0);
    rd(4'hC, d); check("R1 flag", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2: control field mask, unaligned offsets ignored
    wr(4'h8, 32'hABCD_5AFC); rd(4'h8, d); check("R2 ctrl mask", d, 32'h0000_5A00);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h77);
    wr(4'h3, 32'h9);
    rd(4'h0, d); check("R2 unaligned write ignored", d, 32'h77);
    rd(4'h1, d); check("R2 unaligned read zero", d, 32'h0);
    // R9: disabled counter reads zero
    rd(4'h4, d); check("R9 disabled read", d, 32'h0);

    // R3: P=0 steps once per clock
    wr(4'h8, 32'h1); rd(4'h4, d); check("R3 start value", d, 32'h77);
    idle(4); rd(4'h4, d); check("R3 four steps", d, 32'h73);

    // R5: direct counter write
    wr(4'h4, 32'd20); rd(4'h4, d); check("R5 count write", d, 32'd20);
    idle(3); rd(4'h4, d); check("R5 counts on", d, 32'd17);

    // R4: reload write copies into counter
    wr(4'h0, 32'd9); rd(4'h4, d); check("R4 count copy", d, 32'd9);
    rd(4'h0, d); check("R4 load stored", d, 32'd9);

    // R12: expiry on the same edge as a flag clear
    idle(8);
    wr(4'hC, 32'h1);
    rd(4'hC, d); check("R12 set beats clear", d, 32'h1);
    check("R6 irq level", {31'b0, irq}, 32'h1);
    rd(4'h4, d); check("R6 one-shot parks", d, 32'h0);
    wr(4'hC, 32'h0); rd(4'hC, d); check("R10 zero write keeps", d, 32'h1);
    wr(4'hC, 32'h1); rd(4'hC, d); check("R10 one write clears", d, 32'h0);
    check("R10 irq follows", {31'b0, irq}, 32'h0);
    idle(5); check("R11 no new irq", {31'b0, irq}, 32'h0);

    // R8: enable rising with zero count in periodic mode
    wr(4'h8, 32'h0); wr(4'h0, 32'd6); wr(4'h4, 32'h0);
    wr(4'h8, 32'h3); rd(4'h4, d); check("R8 preload", d, 32'd6);
    // R11: one-shot enable on zero count stays idle
    wr(4'h8, 32'h0); wr(4'h4, 32'h0); wr(4'hC, 32'h1);
    wr(4'h8, 32'h1); idle(3);
    rd(4'h4, d); check("R11 zero stays", d, 32'h0);
    rd(4'hC, d); check("R11 no flag", d, 32'h0);

    // R12: counter write on a decrement edge
    wr(4'h8, 32'h0); wr(4'h4, 32'd40); wr(4'h8, 32'h1); idle(2);
    wr(4'h4, 32'd50); rd(4'h4, d); check("R12 write beats step", d, 32'd50);

    // R3: first step P+1 clocks after restart, P=4
    wr(4'h8, 32'h0); wr(4'h0, 32'd10); wr(4'h8, 32'h0401);
    idle(4); rd(4'h4, d); check("R3 prescale hold", d, 32'd10);
    idle(1); rd(4'h4, d); check("R3 prescale step", d, 32'd9);

    // Vector table: R3 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h1);
      wr(4'h0, {16'b0, VECS[i].v});
      wr(4'h8, {16'b0, VECS[i].p, 6'b0, VECS[i].ar, 1'b1});
      idle(int'(VECS[i].w));
      rd(4'h4, d); check($sformatf("R3 R7 vec%0d count", i), d, VECS[i].ecnt);
      rd(4'hC, d); check($sformatf("R6 vec%0d flag", i), d, {31'b0, VECS[i].ests});
      check($sformatf("R10 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].ests});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule